// File: doc/BRIEF.md
# Crossbar Virtual-Output-Queue Matching Scheduler

This block decides, once per timeslot, which inputs of an N-by-N crossbar are connected to which outputs. Every input keeps a separate queue for each output. It reports one request bit per output, and the bit is set while that queue holds a packet. A packet stuck behind a busy output therefore never stalls traffic that is waiting for a free output. The scheduler takes the full request matrix at the start of a slot and returns a grant matrix. In that matrix each input holds at most one output and each output serves at most one input.

The matching is built in rounds. In each round, every free output offers itself to one free requesting input, picked by round robin. Every input that receives offers then takes one of them, also by round robin. The block runs exactly N rounds. That is enough to leave no free input still asking for a free output, so the result is a maximal matching. A fabric with twice the line rate reaches full throughput with any maximal matching. A one-cycle done pulse marks the final grant, and the grant then holds until the next slot begins. The round-robin pointers move only on matches made in the first round, which spreads service evenly across contending inputs and outputs over successive slots.

Top module: `voq_match_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, `grant_o` is all zeros and `done_o` is low.
- R2: At the done pulse, every row of the grant (bits `i*N` to `i*N+N-1`, input `i`) has at most one bit set.
- R3: At the done pulse, every column of the grant (bit `i*N+j` over all `i`, output `j`) has at most one bit set.
- R4: A grant bit `i*N+j` is set only if request bit `i*N+j` was set in the cycle `slot_start_i` was sampled.
- R5: At the done pulse the grant is maximal. No request bit `i*N+j` is set while row `i` and column `j` of the grant are both empty.
- R6: If `slot_start_i` is high at clock edge k, then `done_o` is high for exactly one cycle, the one following edge k+N, and low in the cycles after edges k+1 to k+N-1.
- R7: After the done pulse, `grant_o` does not change until the next `slot_start_i`, whatever `req_i` does meanwhile.
- R8: When two inputs request only the same single output, and nothing else is requested, consecutive slots grant that output to alternating inputs.
- R9: When a single input requests exactly two outputs, and nothing else is requested, consecutive slots grant it alternating outputs.
- R10: If every request bit is set, the done grant has exactly N bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_start_i | input | 1 | Starts a slot; `req_i` is captured on this edge |
| req_i | input | N*N | Request matrix, bit `i*N+j` = input `i` has a packet queued for output `j` |
| grant_o | output | N*N | Grant matrix in the same bit layout |
| done_o | output | 1 | One-cycle pulse marking the final grant of the slot |

## Verification
The bench runs several thousand pseudo-random request matrices of mixed density. Against each one it checks row and column exclusivity, containment in the request, maximality and the latency. These are the cases where a round that drops a free pair or double-books an output would show. Fixed patterns cover specific failures. An empty matrix catches spurious grants. A full matrix must give a complete permutation. A single column and a single row test exclusivity at its tightest. Two contention patterns repeated across slots show whether the output-side and input-side pointers rotate, as opposed to always favouring the lowest index.

// File: rtl/voq_match_sched_pkg.sv
// Package: shared helpers for the crossbar matching scheduler.
// Assumes indices are smaller than the modulus passed in.
package voq_match_sched_pkg;

    // Next index after v in a ring of n positions.
    function automatic int unsigned ring_next(int unsigned v, int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/voq_rr_pick.sv
// Round-robin picker: selects the first set request at or after the
// pointer, wrapping around. Purely combinational.
// Assumes ptr_i < N.
module voq_rr_pick #(
    parameter int N  = 4,
    parameter int PW = 2
) (
    input  logic [N-1:0]  req_i,
    input  logic [PW-1:0] ptr_i,
    output logic [N-1:0]  gnt_o,
    output logic [PW-1:0] idx_o
);

    int unsigned pos;

    // Scan offsets from far to near so the nearest requester wins last.
    always_comb begin
        gnt_o = '0;
        idx_o = '0;
        pos   = 0;
        for (int k = N - 1; k >= 0; k--) begin
            pos = (int'(ptr_i) + k) % N;
            if (req_i[pos]) begin
                gnt_o      = '0;
                gnt_o[pos] = 1'b1;
                idx_o      = PW'(pos);
            end
        end
    end

endmodule

// File: rtl/voq_match_round.sv
// One request-grant-accept round. Free outputs each offer to one free
// requesting input; each input accepts one offer. Combinational.
// Assumes match_i is already conflict-free.
module voq_match_round #(
    parameter int N  = 4,
    parameter int PW = 2
) (
    input  logic [N-1:0][N-1:0]  req_i,     // [input][output]
    input  logic [N-1:0][N-1:0]  match_i,   // [input][output]
    input  logic [N-1:0][PW-1:0] gptr_i,    // per output
    input  logic [N-1:0][PW-1:0] aptr_i,    // per input
    output logic [N-1:0][N-1:0]  acc_o,     // new pairs [input][output]
    output logic [N-1:0][PW-1:0] gidx_o,    // input chosen per output
    output logic [N-1:0][PW-1:0] aidx_o,    // output chosen per input
    output logic [N-1:0]         out_won_o, // output's offer was taken
    output logic [N-1:0]         in_won_o   // input accepted an offer
);

    logic [N-1:0]        free_in;
    logic [N-1:0]        free_out;
    logic [N-1:0][N-1:0] out_req;   // [output][input]
    logic [N-1:0][N-1:0] in_offer;  // [input][output]
    wire  [N-1:0][N-1:0] offer;     // [output][input]
    wire  [N-1:0][N-1:0] acc;       // [input][output]

    // Find inputs and outputs not yet matched.
    always_comb begin
        for (int i = 0; i < N; i++) free_in[i] = ~|match_i[i];
        for (int j = 0; j < N; j++) begin
            free_out[j] = 1'b1;
            for (int i = 0; i < N; i++)
                if (match_i[i][j]) free_out[j] = 1'b0;
        end
    end

    // Build per-output request lists restricted to free pairs.
    always_comb begin
        for (int j = 0; j < N; j++)
            for (int i = 0; i < N; i++)
                out_req[j][i] = req_i[i][j] & free_in[i] & free_out[j];
    end

    for (genvar j = 0; j < N; j++) begin : g_out
        voq_rr_pick #(.N(N), .PW(PW)) u_gpick (
            .req_i (out_req[j]),
            .ptr_i (gptr_i[j]),
            .gnt_o (offer[j]),
            .idx_o (gidx_o[j])
        );
    end

    // Turn output offers into per-input offer lists.
    always_comb begin
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                in_offer[i][j] = offer[j][i];
    end

    for (genvar i = 0; i < N; i++) begin : g_in
        voq_rr_pick #(.N(N), .PW(PW)) u_apick (
            .req_i (in_offer[i]),
            .ptr_i (aptr_i[i]),
            .gnt_o (acc[i]),
            .idx_o (aidx_o[i])
        );
    end

    // Summarise which inputs and outputs were matched this round.
    always_comb begin
        acc_o = acc;
        for (int i = 0; i < N; i++) in_won_o[i] = |acc[i];
        for (int j = 0; j < N; j++) begin
            out_won_o[j] = 1'b0;
            for (int i = 0; i < N; i++)
                if (acc[i][j]) out_won_o[j] = 1'b1;
        end
    end

endmodule

// File: rtl/voq_match_sched.sv
// Per-slot maximal matching scheduler for an N-by-N crossbar with
// virtual output queues. Captures requests on slot_start_i, runs N
// rounds (one per cycle), pulses done_o, and holds the grant.
// Assumes slot_start_i is a single-cycle pulse; a new pulse restarts.
module voq_match_sched #(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           slot_start_i,
    input  logic [N*N-1:0] req_i,
    output logic [N*N-1:0] grant_o,
    output logic           done_o
);
    import voq_match_sched_pkg::*;

    localparam int PW = (N > 1) ? $clog2(N) : 1;
    localparam int IW = $clog2(N + 1);

    logic [N-1:0][N-1:0]  req_q;
    logic [N-1:0][N-1:0]  match_q;
    logic [N-1:0][PW-1:0] gptr_q;
    logic [N-1:0][PW-1:0] aptr_q;
    logic                 busy_q;
    logic [IW-1:0]        iter_q;
    logic                 done_q;

    wire [N-1:0][N-1:0]  acc;
    wire [N-1:0][PW-1:0] gidx;
    wire [N-1:0][PW-1:0] aidx;
    wire [N-1:0]         out_won;
    wire [N-1:0]         in_won;

    logic first_round;
    assign first_round = busy_q && !slot_start_i && (iter_q == '0);

    voq_match_round #(.N(N), .PW(PW)) u_round (
        .req_i     (req_q),
        .match_i   (match_q),
        .gptr_i    (gptr_q),
        .aptr_i    (aptr_q),
        .acc_o     (acc),
        .gidx_o    (gidx),
        .aidx_o    (aidx),
        .out_won_o (out_won),
        .in_won_o  (in_won)
    );

    // Slot sequencing: capture, iterate N rounds, flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= '0;
            match_q <= '0;
            busy_q  <= 1'b0;
            iter_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (slot_start_i) begin
                req_q   <= req_i;
                match_q <= '0;
                busy_q  <= 1'b1;
                iter_q  <= '0;
            end else if (busy_q) begin
                match_q <= match_q | acc;
                iter_q  <= iter_q + 1'b1;
                if (iter_q == IW'(N - 1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    // Pointer update: only pairs accepted in the first round move pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gptr_q <= '0;
            aptr_q <= '0;
        end else if (first_round) begin
            for (int j = 0; j < N; j++)
                if (out_won[j]) gptr_q[j] <= PW'(ring_next(int'(gidx[j]), N));
            for (int i = 0; i < N; i++)
                if (in_won[i]) aptr_q[i] <= PW'(ring_next(int'(aidx[i]), N));
        end
    end

    assign grant_o = match_q;
    assign done_o  = done_q;

    // ---------------- assertions ----------------
    logic [N-1:0] row_used;
    logic [N-1:0] col_used;
    logic [N-1:0][N-1:0] g2d;
    assign g2d = grant_o;

    // Occupancy of grant rows and columns for the checks below.
    always_comb begin
        for (int i = 0; i < N; i++) row_used[i] = |g2d[i];
        for (int j = 0; j < N; j++) begin
            col_used[j] = 1'b0;
            for (int i = 0; i < N; i++)
                if (g2d[i][j]) col_used[j] = 1'b1;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_chk_row
        logic [N-1:0] col_bits;
        always_comb for (int r = 0; r < N; r++) col_bits[r] = g2d[r][i];

        assert_row_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(g2d[i]));
        assert_col_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col_bits));
        assert_grant_in_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
            done_o |-> ((g2d[i] & ~req_q[i]) == '0));
        for (genvar j = 0; j < N; j++) begin : g_chk_max
            assert_maximal_R5: assert property (@(posedge clk) disable iff (!rst_n)
                done_o |-> !(req_q[i][j] && !row_used[i] && !col_used[j]));
        end
    end

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_q));
    assert_grant_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !done_o && !$past(slot_start_i)) |-> $stable(grant_o));

endmodule

// File: tb/voq_match_sched_tb_top.sv
// Self-checking bench: fixed corner patterns, fairness sequences and a
// long pseudo-random sweep over a 4x4 scheduler.
module voq_match_sched_tb_top;
    localparam int N  = 4;
    localparam int NN = N * N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slot_start = 1'b0;
    logic [NN-1:0] req = '0;
    wire  [NN-1:0] grant;
    wire           done;

    int total = 0;
    int bad   = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;

    voq_match_sched #(.N(N)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_start_i (slot_start),
        .req_i        (req),
        .grant_o      (grant),
        .done_o       (done)
    );

    // Record one check; print a FAIL line when it does not hold.
    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit rows_ok(input logic [NN-1:0] g);
        for (int i = 0; i < N; i++)
            if ($countones(g[i*N +: N]) > 1) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit cols_ok(input logic [NN-1:0] g);
        for (int j = 0; j < N; j++) begin
            int c = 0;
            for (int i = 0; i < N; i++) c += int'(g[i*N+j]);
            if (c > 1) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic bit is_maximal(input logic [NN-1:0] g, input logic [NN-1:0] r);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                bit col_busy = 1'b0;
                for (int k = 0; k < N; k++) if (g[k*N+j]) col_busy = 1'b1;
                if (r[i*N+j] && (g[i*N +: N] == '0) && !col_busy) return 1'b0;
            end
        return 1'b1;
    endfunction

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13;
        x ^= x >> 17;
        x ^= x << 5;
        return x;
    endfunction

    // Run one slot with pattern p, check R2-R7 and return the grant.
    task automatic run_slot(input logic [NN-1:0] p, output logic [NN-1:0] g);
        bit lat_ok = 1'b1;
        @(negedge clk);
        req = p;
        slot_start = 1'b1;
        @(negedge clk);            // after edge k
        slot_start = 1'b0;
        for (int c = 1; c <= N; c++) begin
            @(negedge clk);        // after edge k+c
            if ((c < N) && done) lat_ok = 1'b0;
            if ((c == N) && !done) lat_ok = 1'b0;
        end
        g = grant;
        check(lat_ok, "R6", "done timing", 32'(done), 32'd1);
        check(rows_ok(g), "R2", "row exclusivity", 32'(g), 32'(p));
        check(cols_ok(g), "R3", "column exclusivity", 32'(g), 32'(p));
        check((g & ~p) == '0, "R4", "grant within request", 32'(g & ~p), 32'd0);
        check(is_maximal(g, p), "R5", "maximal matching", 32'(g), 32'(p));
        req = ~p;                  // inputs move; the grant must not
        @(negedge clk);
        check(!done, "R6", "done one cycle", 32'(done), 32'd0);
        @(negedge clk);
        @(negedge clk);
        check(grant == g, "R7", "grant held", 32'(grant), 32'(g));
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R6 watchdog expired: actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [NN-1:0] g;
        logic [NN-1:0] prev;

        // R1: reset state.
        repeat (3) @(negedge clk);
        check(grant == '0, "R1", "grant in reset", 32'(grant), 32'd0);
        check(!done, "R1", "done in reset", 32'(done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(grant == '0 && !done, "R1", "state after reset",
              32'({done, grant}), 32'd0);

        // Empty request: nothing granted.
        run_slot('0, g);
        check(g == '0, "R4", "empty request", 32'(g), 32'd0);

        // R10: full request gives a complete permutation.
        for (int s = 0; s < 3; s++) begin
            run_slot('1, g);
            check($countones(g) == N, "R10", "full request count",
                  32'($countones(g)), 32'(N));
        end

        // Single column: exactly one input wins output 2.
        run_slot(NN'(16'h4444), g);
        check($countones(g) == 1, "R3", "single column one winner",
              32'($countones(g)), 32'd1);

        // Single row: input 1 gets exactly one output.
        run_slot(NN'(16'h00F0), g);
        check($countones(g) == 1, "R2", "single row one output",
              32'($countones(g)), 32'd1);

        // Diagonal: every pair granted.
        run_slot(NN'(16'h8421), g);
        check(g == NN'(16'h8421), "R5", "diagonal fully granted",
              32'(g), 32'h8421);

        // R8: inputs 0 and 1 contend for output 0 (bits 0 and N).
        run_slot(NN'(1) | (NN'(1) << N), prev);
        for (int s = 0; s < 4; s++) begin
            run_slot(NN'(1) | (NN'(1) << N), g);
            check((g != prev) && ($countones(g) == 1), "R8",
                  "output-side rotation", 32'(g), 32'(~prev & (NN'(1) | (NN'(1) << N))));
            prev = g;
        end

        // R9: input 0 requests outputs 0 and 1 (bits 0 and 1).
        run_slot(NN'(3), prev);
        for (int s = 0; s < 4; s++) begin
            run_slot(NN'(3), g);
            check((g != prev) && ($countones(g) == 1), "R9",
                  "input-side rotation", 32'(g), 32'(~prev & NN'(3)));
            prev = g;
        end

        // Random sweep of mixed density.
        for (int t = 0; t < 6000; t++) begin
            logic [NN-1:0] p;
            seed = next_rand(seed);
            p = seed[NN-1:0];
            if (t % 3 == 1) p &= seed[31:32-NN];
            if (t % 3 == 2) p |= seed[31:32-NN];
            run_slot(p, g);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule